// File: doc/BRIEF.md
# Four-Wide Issue Group Legality Checker

This block sits in an in-order issue stage. Each cycle it looks at a window of up to four decoded instructions, oldest first, and decides how many of them, starting from the oldest, may leave together as one issue group. Every instruction carries a class code and three flags: one for setting the condition codes, one for being a load, and one for being a taken branch. The block applies a fixed set of pairing and slot-position rules. These cover integer ordering, condition-code placement, one unit of each other kind, and keeping integer and memory operations out of the last slot. It also holds a short history of recent load issues, so that an integer conditional move is held back for five issuing cycles after a load.

The group is the longest legal prefix of the window. The first instruction that breaks a rule, or the first empty slot, closes the group. The decision is registered and appears on the outputs one cycle after the window is presented, as a count and a matching contiguous mask. A stall input cancels issue for that cycle and freezes the load history.

Top module: `issue_group_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `issue_count` and `issue_mask` are zero. The load history is clear on reset, so a conditional move may issue in the first window after reset.
- R2: The window presented in cycle t is judged in cycle t and the result shows on the outputs in cycle t+1. The mask has bit i set for each issued slot i, with slot 0 the oldest. The mask is always a run of ones from bit 0, and the count equals the number of ones in it. A slot with its valid bit low ends the group. Class codes sit in `win_cls[3i+:3]`: 0 shift, 1 integer add/sub/logical, 2 load/store, 3 FP add-class, 4 FP multiply, 5 branch, 6 integer conditional move, 7 reserved.
- R3: A group holds at most two integer instructions (codes 0 and 1), and at most one of them may be a shift. A shift cannot follow an integer instruction of the same group.
- R4: If an integer instruction with its condition-code flag set is already in the group, no further integer instruction may join it.
- R5: A group holds at most one load/store, one FP add-class op, one FP multiply and one branch.
- R6: Shift, integer, load/store and conditional-move instructions never issue from slot 3, the fourth slot.
- R7: A branch with its taken flag set never issues from slot 3. A branch that is not taken may issue from slot 3.
- R8: A conditional move never shares a group with a shift, an integer instruction or another conditional move.
- R9: A load is a load/store (code 2) with its load flag set. A conditional move cannot issue in any of the five non-stalled cycles that follow a cycle in which a load issued. It may issue in the sixth.
- R10: When `stall` is high, the result for that cycle is a count of zero, and that cycle neither records a load nor ages the load history.
- R11: An instruction with the reserved class code 7 never issues and ends the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Cancel issue this cycle and hold the load history |
| win_valid | input | 4 | Per-slot valid, bit 0 oldest |
| win_cls | input | 12 | Per-slot 3-bit class code, slot i at bits 3i+2..3i |
| win_setcc | input | 4 | Per-slot sets-condition-codes flag |
| win_load | input | 4 | Per-slot is-a-load flag |
| win_taken | input | 4 | Per-slot taken-branch flag |
| issue_count | output | 3 | Number of instructions issued (0 to 4), registered |
| issue_mask | output | 4 | Per-slot issue mask, contiguous from bit 0, registered |

## Verification
Directed windows pair each rule with a near miss that differs in one field: shift then integer against integer then shift, the condition-code setter second against first, and a taken against an untaken branch in the last slot. Each pair shows that the rule's condition is the thing that closes the group, not the mere presence of the class. A load followed by a run of conditional moves, with stalls placed inside the run, locates the end of the five-cycle window and shows that stalled cycles do not age it. Long stretches of random windows with mostly-valid slots exercise the mixed combinations against a behavioural model that is compared on every cycle.

// File: rtl/igc_pkg.sv
package igc_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    IC_SHIFT  = 3'd0,
    IC_ALU    = 3'd1,
    IC_MEM    = 3'd2,
    IC_FADD   = 3'd3,
    IC_FMUL   = 3'd4,
    IC_BRANCH = 3'd5,
    IC_CMOV   = 3'd6,
    IC_RSVD   = 3'd7
  } iclass_e;

  typedef struct packed {
    logic vld;
    logic shift;
    logic alu;
    logic mem;
    logic fadd;
    logic fmul;
    logic br;
    logic cmov;
    logic setcc;
    logic load;
  } slot_dec_t;

endpackage

// File: rtl/igc_slot_decode.sv
module igc_slot_decode
  import igc_pkg::*;
#(
  parameter int SLOT = 0,
  parameter int LAST = 3
) (
  input  logic             valid,
  input  logic [CLS_W-1:0] cls,
  input  logic             setcc,
  input  logic             load,
  input  logic             taken,
  output slot_dec_t        dec,
  output logic             pos_bad
);

  always_comb begin
    dec = '0;
    dec.vld = valid;
    if (valid) begin
      case (iclass_e'(cls))
        IC_SHIFT:  dec.shift = 1'b1;
        IC_ALU:    dec.alu   = 1'b1;
        IC_MEM:    dec.mem   = 1'b1;
        IC_FADD:   dec.fadd  = 1'b1;
        IC_FMUL:   dec.fmul  = 1'b1;
        IC_BRANCH: dec.br    = 1'b1;
        IC_CMOV:   dec.cmov  = 1'b1;
        default:   dec       = '{vld: 1'b1, default: 1'b0};
      endcase
      dec.setcc = setcc & (dec.shift | dec.alu);
      dec.load  = load & dec.mem;
    end
  end

  // Only the final slot carries position restrictions.
  generate
    if (SLOT == LAST) begin : g_last
      assign pos_bad = dec.shift | dec.alu | dec.mem | dec.cmov | (dec.br & taken);
    end else begin : g_inner
      assign pos_bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/igc_prefix_scan.sv
module igc_prefix_scan
  import igc_pkg::*;
#(
  parameter int W = 4
) (
  input  slot_dec_t    dec [W],
  input  logic [W-1:0] pos_bad,
  input  logic         hist_clear,
  output logic [W-1:0] mask,
  output logic         load_issued
);

  logic [1:0] n_int;
  logic       saw_cc, saw_cmov, saw_mem, saw_fa, saw_fm, saw_br;
  logic       run, ok;

  always_comb begin
    n_int = '0;
    saw_cc = 1'b0; saw_cmov = 1'b0; saw_mem = 1'b0;
    saw_fa = 1'b0; saw_fm = 1'b0; saw_br = 1'b0;
    run = 1'b1;
    ok = 1'b0;
    mask = '0;
    load_issued = 1'b0;
    for (int i = 0; i < W; i++) begin
      ok = 1'b0;
      if (dec[i].shift)     ok = (n_int == 2'd0) && !saw_cmov;
      else if (dec[i].alu)  ok = (n_int < 2'd2) && !saw_cmov && !saw_cc;
      else if (dec[i].mem)  ok = !saw_mem;
      else if (dec[i].fadd) ok = !saw_fa;
      else if (dec[i].fmul) ok = !saw_fm;
      else if (dec[i].br)   ok = !saw_br;
      else if (dec[i].cmov) ok = (n_int == 2'd0) && !saw_cmov && hist_clear;
      ok = ok && run && dec[i].vld && !pos_bad[i];
      mask[i] = ok;
      run = ok;
      if (ok) begin
        if (dec[i].shift || dec[i].alu) n_int = n_int + 2'd1;
        saw_cc   = saw_cc   | dec[i].setcc;
        saw_cmov = saw_cmov | dec[i].cmov;
        saw_mem  = saw_mem  | dec[i].mem;
        saw_fa   = saw_fa   | dec[i].fadd;
        saw_fm   = saw_fm   | dec[i].fmul;
        saw_br   = saw_br   | dec[i].br;
        load_issued = load_issued | dec[i].load;
      end
    end
  end

endmodule

// File: rtl/igc_load_history.sv
module igc_load_history #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic load_in,
  output logic clear
);

  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst)          hist <= '0;
    else if (advance) hist <= {hist[DEPTH-2:0], load_in};
  end

  assign clear = (hist == '0);

  // R10: stalled cycles leave the history untouched
  a_r10_hist_frozen: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(hist));

  // R9: an issued load blocks conditional moves in the next cycle
  a_r9_load_blocks: assert property (@(posedge clk) disable iff (rst)
    (advance && load_in) |=> !clear);

endmodule

// File: rtl/issue_group_checker.sv
module issue_group_checker
  import igc_pkg::*;
#(
  parameter int W          = 4,
  parameter int HIST_DEPTH = 5,
  localparam int CW        = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic [W-1:0]       win_valid,
  input  logic [W*CLS_W-1:0] win_cls,
  input  logic [W-1:0]       win_setcc,
  input  logic [W-1:0]       win_load,
  input  logic [W-1:0]       win_taken,
  output logic [CW-1:0]      issue_count,
  output logic [W-1:0]       issue_mask
);

  slot_dec_t    dec [W];
  logic [W-1:0] pos_bad;
  logic [W-1:0] scan_mask;
  logic         load_issued;
  logic         hist_clear;

  for (genvar s = 0; s < W; s++) begin : g_slot
    igc_slot_decode #(.SLOT(s), .LAST(W - 1)) u_dec (
      .valid   (win_valid[s]),
      .cls     (win_cls[s*CLS_W +: CLS_W]),
      .setcc   (win_setcc[s]),
      .load    (win_load[s]),
      .taken   (win_taken[s]),
      .dec     (dec[s]),
      .pos_bad (pos_bad[s])
    );
  end

  igc_prefix_scan #(.W(W)) u_scan (
    .dec         (dec),
    .pos_bad     (pos_bad),
    .hist_clear  (hist_clear),
    .mask        (scan_mask),
    .load_issued (load_issued)
  );

  igc_load_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .advance (!stall),
    .load_in (load_issued),
    .clear   (hist_clear)
  );

  function automatic logic [CW-1:0] ones(input logic [W-1:0] m);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(m[i]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      issue_count <= '0;
      issue_mask  <= '0;
    end else begin
      issue_count <= ones(scan_mask);
      issue_mask  <= scan_mask;
    end
  end

  // R2: count agrees with the mask
  a_r2_count_mask: assert property (@(posedge clk) disable iff (rst)
    issue_count == CW'($countones(issue_mask)));

  // R2: the mask is a run of ones from slot 0
  a_r2_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((issue_mask + W'(1)) & issue_mask) == '0);

  // R10: a stall yields an empty group
  a_r10_stall_zero: assert property (@(posedge clk) disable iff (rst)
    stall |=> (issue_count == '0));

  // R6: load/store never leaves from the last slot
  a_r6_mem_not_last: assert property (@(posedge clk) disable iff (rst)
    (win_valid[W-1] && win_cls[(W-1)*CLS_W +: CLS_W] == IC_MEM) |=> !issue_mask[W-1]);

  // R8: conditional move in slot 0 keeps an integer op out of slot 1
  a_r8_cmov_alone: assert property (@(posedge clk) disable iff (rst)
    (dec[0].cmov && dec[1].alu) |=> !issue_mask[1]);

endmodule

// File: tb/sim_issue_group_checker.sv
module sim_issue_group_checker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [3:0]  v = '0, cc = '0, ld = '0, tk = '0;
  logic [11:0] cl = '0;
  logic [2:0]  cnt;
  logic [3:0]  msk;

  int total = 0;
  int fails = 0;
  int mh[5];
  int exp_n = 0;
  string exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_group_checker u0 (
    .clk(clk), .rst(rst), .stall(stall),
    .win_valid(v), .win_cls(cl), .win_setcc(cc), .win_load(ld), .win_taken(tk),
    .issue_count(cnt), .issue_mask(msk)
  );

  function automatic logic [11:0] pk(input int a, input int b, input int c, input int d);
    return {d[2:0], c[2:0], b[2:0], a[2:0]};
  endfunction

  // Behavioural reference: greedy walk with per-kind tallies
  function automatic void model(output int n, output bit loaded);
    int ints, shifts, mems, fas, fms, brs, cms;
    bit ccs, busy, ok;
    int c;
    n = 0; loaded = 0;
    ints = 0; shifts = 0; mems = 0; fas = 0; fms = 0; brs = 0; cms = 0; ccs = 0;
    busy = 0;
    for (int k = 0; k < 5; k++) if (mh[k] != 0) busy = 1;
    for (int i = 0; i < 4; i++) begin
      if (!v[i]) break;
      c = int'(cl[3*i +: 3]);
      case (c)
        0: ok = (ints == 0) && (cms == 0) && (i < 3);
        1: ok = (ints < 2) && (cms == 0) && !ccs && (i < 3);
        2: ok = (mems == 0) && (i < 3);
        3: ok = (fas == 0);
        4: ok = (fms == 0);
        5: ok = (brs == 0) && !(tk[i] && i == 3);
        6: ok = (ints == 0) && (cms == 0) && !busy && (i < 3);
        default: ok = 0;
      endcase
      if (!ok) break;
      n++;
      if (c == 0 || c == 1) begin ints++; if (cc[i]) ccs = 1; end
      if (c == 0) shifts++;
      if (c == 2) begin mems++; if (ld[i]) loaded = 1; end
      if (c == 3) fas++;
      if (c == 4) fms++;
      if (c == 5) brs++;
      if (c == 6) cms++;
    end
  endfunction

  task automatic check_out();
    logic [3:0] em;
    em = 4'((1 << exp_n) - 1);
    total++;
    if (cnt !== 3'(exp_n) || msk !== em) begin
      fails++;
      $display("FAIL %s: count=%0d mask=%b expected count=%0d mask=%b",
               exp_tag, cnt, msk, exp_n, em);
    end
  endtask

  task automatic step(input logic [3:0] vv, input logic [11:0] cls, input logic [3:0] ccv,
                      input logic [3:0] ldv, input logic [3:0] tkv, input logic st,
                      input string tag);
    int n;
    bit loaded;
    @(negedge clk);
    check_out();
    v = vv; cl = cls; cc = ccv; ld = ldv; tk = tkv; stall = st;
    model(n, loaded);
    if (st) n = 0;
    else begin
      for (int k = 4; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = loaded ? 1 : 0;
    end
    exp_n = n;
    exp_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) mh[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_n = 0; exp_tag = "R1";
    check_out();
    rst = 1'b0;
    // R1: cmov allowed right after reset
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R1");
    // R2: gap ends group, full legal group
    step(4'b1101, pk(3,4,1,0), 0, 0, 0, 0, "R2");
    step(4'b1111, pk(0,1,3,4), 0, 0, 0, 0, "R2");
    // R3
    step(4'b0011, pk(1,0,0,0), 0, 0, 0, 0, "R3");
    step(4'b0011, pk(0,0,0,0), 0, 0, 0, 0, "R3");
    step(4'b0111, pk(1,1,1,0), 0, 0, 0, 0, "R3");
    // R4
    step(4'b0011, pk(1,1,0,0), 4'b0001, 0, 0, 0, "R4");
    step(4'b0011, pk(1,1,0,0), 4'b0010, 0, 0, 0, "R4");
    step(4'b0011, pk(0,1,0,0), 4'b0001, 0, 0, 0, "R4");
    // R5
    step(4'b0011, pk(3,3,0,0), 0, 0, 0, 0, "R5");
    step(4'b0011, pk(2,2,0,0), 0, 0, 0, 0, "R5");
    step(4'b0011, pk(5,5,0,0), 0, 0, 0, 0, "R5");
    step(4'b0011, pk(4,4,0,0), 0, 0, 0, 0, "R5");
    // R6
    step(4'b1111, pk(3,4,5,2), 0, 0, 0, 0, "R6");
    step(4'b1111, pk(3,4,2,1), 0, 0, 0, 0, "R6");
    step(4'b1111, pk(3,4,2,0), 0, 0, 0, 0, "R6");
    // R7
    step(4'b1111, pk(3,4,2,5), 0, 0, 4'b1000, 0, "R7");
    step(4'b1111, pk(3,4,2,5), 0, 0, 4'b0000, 0, "R7");
    // R8
    step(4'b0011, pk(6,1,0,0), 0, 0, 0, 0, "R8");
    step(4'b0011, pk(1,6,0,0), 0, 0, 0, 0, "R8");
    step(4'b0011, pk(6,6,0,0), 0, 0, 0, 0, "R8");
    step(4'b1111, pk(6,3,4,2), 0, 0, 0, 0, "R8");
    // R11
    step(4'b0111, pk(3,7,4,0), 0, 0, 0, 0, "R11");
    // R9 with R10 stalls inside the window
    step(4'b0001, pk(2,0,0,0), 0, 4'b0001, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R9");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 1, "R10");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 1, "R10");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R9");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R9");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R9");
    // R9: store (no load flag) does not block
    step(4'b0001, pk(2,0,0,0), 0, 0, 0, 0, "R9");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R9");
    // R10: stall with a load does not record it
    step(4'b0001, pk(2,0,0,0), 0, 4'b0001, 0, 1, "R10");
    step(4'b0001, pk(6,0,0,0), 0, 0, 0, 0, "R10");
    // Random windows
    for (int r = 0; r < 3000; r++) begin
      logic [3:0] rv;
      rv = 4'($urandom);
      rv = rv | 4'($urandom) | 4'($urandom);
      step(rv, 12'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
           ($urandom % 10) == 0, "R2");
    end
    step(0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    check_out();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule